// File: doc/BRIEF.md
# Asynchronous Packet Address Filter

This block sits on the receive path of a serial bus node. It inspects the first word of every arriving asynchronous packet, which holds a 64-bit destination address. The upper 16 bits of that address name a node: a 10-bit bus number in the high part and a 6-bit physical number in the low part. The lower 48 bits are an offset into that node's register and memory space. When the node part of the address matches the node's own identity, the filter copies the words that follow the header into a receive FIFO and presents the 48-bit offset unchanged to the logic behind it. Packets for any other node are dropped in full, with no FIFO writes.

A physical number of all ones acts as a broadcast. Every node on the addressed bus accepts it. The node identity is written through a small configuration port. A new value is held back until the filter is between packets, so a packet already in progress is always judged against one identity. If the FIFO reports full during an accepted packet, the filter stops writing, raises an overflow flag for that packet and discards the remaining words.

Top module: `async_addr_filter`

## Requirements
- R1: Word layout on `in_data` and `cfg_id`: header bits [63:54] are the destination bus number, [53:48] the destination physical number, [47:0] the offset. A header matches only when its bus number equals bits [15:6] of the active local ID and its physical number equals bits [5:0], or is the broadcast value covered by R5.
- R2: One cycle after a matching header, `dst_offset` equals header bits [47:0]. It keeps that value through later packets, including missed ones, until the next matching header.
- R3: For a matching packet, each word after the header is written to the FIFO in the same cycle it arrives (`fifo_we`=1, `fifo_data` = the word), in arrival order. `fifo_last` is high only with the word that carries end-of-packet. The header word itself is never written.
- R4: For a header that does not match, no FIFO write occurs for any word of that packet, through end-of-packet.
- R5: A header physical number of 63 (all ones) matches when the bus number equals the local bus number. With a different bus number it does not match.
- R6: `hit` is updated one cycle after each header to that header's match result. It holds until the next header.
- R7: If `fifo_full` is high when a payload word of an accepted packet arrives, that word is not written and `ovf_err` goes high in the next cycle. No further word of the packet is written, even after `fifo_full` falls. `ovf_err` clears one cycle after the next header.
- R8: A value written on `cfg_id` with `cfg_we` high becomes the active local ID only while no packet is in progress. A packet that is in progress when the write occurs keeps being accepted against the old ID, and every later header that starts after at least two idle cycles is compared with the new ID.
- R9: After reset `hit`, `ovf_err` and `dst_offset` are zero, no write occurs, and the active local ID is the RESET_ID parameter (default 0x0001).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the local node ID |
| cfg_id | input | 16 | New local node ID (bus number high, physical number low) |
| in_valid | input | 1 | A packet word is present this cycle |
| in_sop | input | 1 | The present word is a header |
| in_eop | input | 1 | The present word ends the packet |
| in_data | input | 64 | Packet word; header carries the destination address |
| fifo_full | input | 1 | Receive FIFO cannot take a word this cycle |
| fifo_we | output | 1 | Receive FIFO write strobe |
| fifo_data | output | 64 | Word written to the FIFO |
| fifo_last | output | 1 | Written word ends the packet |
| dst_offset | output | 48 | Offset from the last accepted header |
| hit | output | 1 | Last header matched this node |
| ovf_err | output | 1 | Current packet lost words to a full FIFO |

## Verification
The bench builds the filter with its default parameters: a 10-bit bus field, a 6-bit physical field, a 48-bit offset, a 64-bit word, broadcast enabled and a reset ID of 0x0001. With those values it can send headers that differ from the local ID only in the top bus bit, only in one physical bit, or only in being a broadcast on another bus. It can also send single-word packets that end on the header. Because the full 48-bit offset path is built, a distinct offset for each packet shows whether the offset register holds or updates. A configuration write that lands in the middle of a packet shows the difference between the pending ID and the active ID at the packet boundary.

// File: rtl/ascfilt_pkg.sv
// Package: shared types for the asynchronous packet address filter.
// Assumes: nothing beyond IEEE 1800-2017.
package ascfilt_pkg;

    // Packet-level state of the filter
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // between packets
        ST_ACCEPT = 2'd1,   // header matched, payload goes to the FIFO
        ST_DROP   = 2'd2    // header missed or FIFO overflowed, discard to EOP
    } flt_state_t;

endpackage

// File: rtl/node_id_cfg.sv
// Module: node_id_cfg
// Holds the local node identity. A configuration write lands in a pending
// register. The active register copies it only on cycles when the filter is
// idle and no header is arriving, so a packet never sees an identity change.
// Assumes: idle_i is high exactly when no packet is in progress.
module node_id_cfg #(
    parameter int          ID_W     = 16,
    parameter int unsigned RESET_ID = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [ID_W-1:0] cfg_id,
    input  logic            idle_i,
    input  logic            hdr_i,
    output logic [ID_W-1:0] active_id
);

    logic [ID_W-1:0] pending_id;

    // Capture software writes as they arrive
    always_ff @(posedge clk) begin
        if (!rst_n)      pending_id <= ID_W'(RESET_ID);
        else if (cfg_we) pending_id <= cfg_id;
    end

    // Promote the pending identity only at a packet boundary
    always_ff @(posedge clk) begin
        if (!rst_n)                  active_id <= ID_W'(RESET_ID);
        else if (idle_i && !hdr_i)   active_id <= pending_id;
    end

endmodule

// File: rtl/hdr_match.sv
// Module: hdr_match
// Combinational decode of a destination address: splits the node field into
// bus and physical parts, compares them with the local identity, and hands
// out the offset field untouched. The broadcast physical number (all ones)
// is honoured when BCAST_EN is set.
// Assumes: the address occupies the low ID_W+OFFS_W bits of the header.
module hdr_match #(
    parameter int BUS_W    = 10,
    parameter int PHY_W    = 6,
    parameter int OFFS_W   = 48,
    parameter bit BCAST_EN = 1'b1,
    localparam int ID_W    = BUS_W + PHY_W,
    localparam int ADDR_W  = ID_W + OFFS_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ID_W-1:0]   local_id,
    output logic              match_o,
    output logic [OFFS_W-1:0] offset_o
);

    logic [BUS_W-1:0] dst_bus;
    logic [PHY_W-1:0] dst_phy;
    logic             bus_ok;
    logic             phy_ok;

    // Split the destination into its fields
    always_comb begin
        dst_bus  = addr_i[ADDR_W-1 -: BUS_W];
        dst_phy  = addr_i[OFFS_W +: PHY_W];
        offset_o = addr_i[OFFS_W-1:0];
        bus_ok   = (dst_bus == local_id[ID_W-1 -: BUS_W]);
    end

    // Physical number compare, with or without the broadcast value
    generate
        if (BCAST_EN) begin : g_bcast
            assign phy_ok = (dst_phy == local_id[PHY_W-1:0]) || (&dst_phy);
        end else begin : g_nobcast
            assign phy_ok = (dst_phy == local_id[PHY_W-1:0]);
        end
    endgenerate

    // Final decision
    assign match_o = bus_ok && phy_ok;

endmodule

// File: rtl/pkt_ctl.sv
// Module: pkt_ctl
// Packet sequencer. On a header it latches the match result and, for a hit,
// the offset. It then either streams payload words straight to the FIFO
// write port or discards them up to end-of-packet. A full FIFO during an
// accepted packet turns the rest of that packet into a drop and sets a
// sticky error that clears on the next header.
// Assumes: well-formed framing (every packet starts with in_sop, ends with
// in_eop); fifo_full reflects whether a write this cycle would be lost.
module pkt_ctl
    import ascfilt_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int OFFS_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              match_i,
    input  logic [OFFS_W-1:0] hdr_offset,
    input  logic              fifo_full,
    output logic              fifo_we,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_last,
    output logic              hit,
    output logic [OFFS_W-1:0] dst_offset,
    output logic              ovf_err,
    output logic              idle_o,
    output logic              hdr_o
);

    flt_state_t state;
    logic       beat;

    // Classify the present word
    always_comb begin
        hdr_o  = in_valid && in_sop;
        beat   = in_valid && !in_sop;
        idle_o = (state == ST_IDLE);
    end

    // Write port: payload of an accepted packet passes through unregistered
    always_comb begin
        fifo_we   = beat && (state == ST_ACCEPT) && !fifo_full;
        fifo_data = in_data;
        fifo_last = fifo_we && in_eop;
    end

    // Packet state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (hdr_o) begin
            if (in_eop)       state <= ST_IDLE;
            else if (match_i) state <= ST_ACCEPT;
            else              state <= ST_DROP;
        end else if (beat) begin
            if (in_eop)                                 state <= ST_IDLE;
            else if (state == ST_ACCEPT && fifo_full)   state <= ST_DROP;
        end
    end

    // Match flag and offset latched at each header
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit        <= 1'b0;
            dst_offset <= '0;
        end else if (hdr_o) begin
            hit <= match_i;
            if (match_i) dst_offset <= hdr_offset;
        end
    end

    // Overflow flag: set on a lost word, cleared by the next header
    always_ff @(posedge clk) begin
        if (!rst_n)                                        ovf_err <= 1'b0;
        else if (hdr_o)                                    ovf_err <= 1'b0;
        else if (beat && state == ST_ACCEPT && fifo_full)  ovf_err <= 1'b1;
    end

    // R7: once a packet has overflowed, nothing more of it reaches the FIFO
    a_r7_drop_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err && !hdr_o) |-> !fifo_we);

    // R4: a missed header leaves the sequencer discarding
    a_r4_miss_discards: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_o && !match_i && !in_eop) |=> (state == ST_DROP));

endmodule

// File: rtl/async_addr_filter.sv
// Module: async_addr_filter (top)
// Receive-side destination filter for asynchronous packets. Compares the
// node field of each header with the local identity (broadcast physical
// number honoured), streams matching payloads to a receive FIFO, exposes the
// 48-bit offset of the last accepted header and flags FIFO overflow.
// Assumes: DATA_W >= BUS_W + PHY_W + OFFS_W; the address sits in the low bits.
module async_addr_filter #(
    parameter int          BUS_W    = 10,
    parameter int          PHY_W    = 6,
    parameter int          OFFS_W   = 48,
    parameter int          DATA_W   = 64,
    parameter bit          BCAST_EN = 1'b1,
    parameter int unsigned RESET_ID = 1,
    localparam int         ID_W     = BUS_W + PHY_W,
    localparam int         ADDR_W   = ID_W + OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              fifo_full,
    output logic              fifo_we,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_last,
    output logic [OFFS_W-1:0] dst_offset,
    output logic              hit,
    output logic              ovf_err
);

    logic [ID_W-1:0]   active_id;
    logic              match;
    logic [OFFS_W-1:0] hdr_offset;
    logic              idle;
    logic              hdr;

    node_id_cfg #(
        .ID_W     (ID_W),
        .RESET_ID (RESET_ID)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_id    (cfg_id),
        .idle_i    (idle),
        .hdr_i     (hdr),
        .active_id (active_id)
    );

    hdr_match #(
        .BUS_W    (BUS_W),
        .PHY_W    (PHY_W),
        .OFFS_W   (OFFS_W),
        .BCAST_EN (BCAST_EN)
    ) u_match (
        .addr_i   (in_data[ADDR_W-1:0]),
        .local_id (active_id),
        .match_o  (match),
        .offset_o (hdr_offset)
    );

    pkt_ctl #(
        .DATA_W (DATA_W),
        .OFFS_W (OFFS_W)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .in_data    (in_data),
        .match_i    (match),
        .hdr_offset (hdr_offset),
        .fifo_full  (fifo_full),
        .fifo_we    (fifo_we),
        .fifo_data  (fifo_data),
        .fifo_last  (fifo_last),
        .hit        (hit),
        .dst_offset (dst_offset),
        .ovf_err    (ovf_err),
        .idle_o     (idle),
        .hdr_o      (hdr)
    );

    // R3: every FIFO write belongs to a packet whose header matched
    a_r3_write_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_we |-> hit);

    // R6: the match flag can only rise right after a header
    a_r6_hit_from_header: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(in_valid && in_sop));

    // R7: an overflow flag is always caused by a full FIFO on a valid word
    a_r7_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_err) |-> $past(in_valid && fifo_full));

    // R2: the offset only moves after a header
    a_r2_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_sop) |=> $stable(dst_offset));

    // R8: the identity stays frozen while a packet is in progress
    a_r8_id_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && $past(!idle)) |-> $stable(active_id));

endmodule

// File: tb/async_addr_filter_tb.sv
`timescale 1ns/1ps
module async_addr_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [15:0] cfg_id;
    logic        in_valid, in_sop, in_eop;
    logic [63:0] in_data;
    logic        fifo_full;
    logic        fifo_we;
    logic [63:0] fifo_data;
    logic        fifo_last;
    logic [47:0] dst_offset;
    logic        hit;
    logic        ovf_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Observed per packet
    int          wr_cnt;
    int          last_cnt;
    int          data_bad;
    logic [47:0] last_acc_off;

    always #2 clk = ~clk;   // 250 MHz

    async_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_id(cfg_id),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .fifo_full(fifo_full), .fifo_we(fifo_we),
        .fifo_data(fifo_data), .fifo_last(fifo_last),
        .dst_offset(dst_offset), .hit(hit), .ovf_err(ovf_err)
    );

    // Vector: [31:16] dest node ID, [15:12] payload words, [11:8] word index
    // at which fifo_full is raised (15 = never), [0] expected accept.
    // Local ID under test is 0xACD5 (bus 0x2B3, phy 0x15).
    localparam logic [31:0] VEC [9] = '{
        {16'hACD5, 4'd3, 4'hF, 7'd0, 1'b1},  // exact match          R1 R3
        {16'hACD4, 4'd2, 4'hF, 7'd0, 1'b0},  // phy differs by 1 bit R1 R4
        {16'hACFF, 4'd4, 4'hF, 7'd0, 1'b1},  // broadcast same bus   R5
        {16'hACBF, 4'd2, 4'hF, 7'd0, 1'b0},  // broadcast other bus  R5
        {16'hAC95, 4'd1, 4'hF, 7'd0, 1'b0},  // bus differs          R1 R4
        {16'h2CD5, 4'd3, 4'hF, 7'd0, 1'b0},  // bus top bit differs  R1
        {16'hACD5, 4'd0, 4'hF, 7'd0, 1'b1},  // header-only packet   R6
        {16'hACD5, 4'd5, 4'd2, 7'd0, 1'b1},  // full at word 2       R7
        {16'hACD5, 4'd1, 4'hF, 7'd0, 1'b1}   // ovf clears           R7
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
            fifo_full = 1'b0; cfg_we = 1'b0;
        end
    endtask

    // Send one packet; record writes. cfg_at: payload index with a config write.
    task automatic send_pkt(input logic [15:0] id, input logic [47:0] off,
                            input int nw, input int full_at, input int vi,
                            input int cfg_at, input logic [15:0] cfg_val);
        wr_cnt = 0; last_cnt = 0; data_bad = 0;
        @(negedge clk);
        in_valid = 1'b1; in_sop = 1'b1; in_eop = (nw == 0);
        in_data = {id, off}; fifo_full = 1'b0; cfg_we = 1'b0;
        #1;
        if (fifo_we) data_bad++;   // header must never be written (R3)
        for (int i = 0; i < nw; i++) begin
            @(negedge clk);
            in_sop = 1'b0; in_eop = (i == nw - 1);
            in_data = {16'hDA7A, 16'(vi), 32'(i)};
            fifo_full = (i == full_at);
            cfg_we = (i == cfg_at); cfg_id = cfg_val;
            #1;
            if (fifo_we) begin
                wr_cnt++;
                if (fifo_data !== in_data) data_bad++;
                if (fifo_last) last_cnt++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        fifo_full = 1'b0; cfg_we = 1'b0;
        #1;
    endtask

    task automatic configure(input logic [15:0] id);
        @(negedge clk);
        cfg_we = 1'b1; cfg_id = id;
        idle(3);
    endtask

    // Send a clean packet and check accept/miss outcome
    task automatic pkt_expect(input logic [15:0] id, input int nw, input bit acc,
                              input int vi, input string req);
        logic [47:0] off;
        off = {16'h0FF5, 16'(vi), 16'h5A5A};
        send_pkt(id, off, nw, 15, vi, 99, 16'h0);
        if (acc) last_acc_off = off;
        check(hit == acc, req, "hit", 64'(hit), 64'(acc));
        check(wr_cnt == (acc ? nw : 0), req, "write count",
              64'(wr_cnt), 64'(acc ? nw : 0));
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_id = '0;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        in_data = '0; fifo_full = 1'b0;
        last_acc_off = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        check(hit == 1'b0,          "R9", "hit after reset", 64'(hit), 0);
        check(ovf_err == 1'b0,      "R9", "ovf after reset", 64'(ovf_err), 0);
        check(dst_offset == 48'h0,  "R9", "offset after reset", 64'(dst_offset), 0);
        check(fifo_we == 1'b0,      "R9", "no write after reset", 64'(fifo_we), 0);

        // R9: reset ID 0x0001 is live; the later ID is not yet
        pkt_expect(16'h0001, 2, 1'b1, 20, "R9");
        pkt_expect(16'hACD5, 2, 1'b0, 21, "R9");

        configure(16'hACD5);

        // Table walk
        for (int v = 0; v < 9; v++) begin
            logic [15:0] id;
            int nw, fa;
            bit acc, ovf_exp;
            int exp_wr, exp_last;
            logic [47:0] off;
            id  = VEC[v][31:16];
            nw  = int'(VEC[v][15:12]);
            fa  = int'(VEC[v][11:8]);
            acc = VEC[v][0];
            ovf_exp  = acc && (fa < nw);
            exp_wr   = !acc ? 0 : (fa < nw ? fa : nw);
            exp_last = (acc && !(fa < nw) && nw > 0) ? 1 : 0;
            off = {16'hBEEF, 16'(v), 16'h1234};
            send_pkt(id, off, nw, fa, v, 99, 16'h0);
            if (acc) last_acc_off = off;
            check(hit == acc, "R1/R5/R6", $sformatf("vec %0d hit", v),
                  64'(hit), 64'(acc));
            check(wr_cnt == exp_wr, "R3/R4/R7", $sformatf("vec %0d writes", v),
                  64'(wr_cnt), 64'(exp_wr));
            check(last_cnt == exp_last, "R3", $sformatf("vec %0d last", v),
                  64'(last_cnt), 64'(exp_last));
            check(data_bad == 0, "R3", $sformatf("vec %0d data/header", v),
                  64'(data_bad), 0);
            check(dst_offset == last_acc_off, "R2", $sformatf("vec %0d offset", v),
                  64'(dst_offset), 64'(last_acc_off));
            check(ovf_err == ovf_exp, "R7", $sformatf("vec %0d ovf", v),
                  64'(ovf_err), 64'(ovf_exp));
            idle(1);
        end

        // R8: config write in mid-packet does not disturb the packet
        send_pkt(16'hACD5, 48'h0000_1357_9BDF, 4, 15, 40, 1, 16'h1111);
        last_acc_off = 48'h0000_1357_9BDF;
        check(wr_cnt == 4, "R8", "mid-packet cfg keeps packet", 64'(wr_cnt), 4);
        check(hit == 1'b1, "R8", "mid-packet hit", 64'(hit), 1);
        idle(2);
        pkt_expect(16'hACD5, 2, 1'b0, 41, "R8");
        pkt_expect(16'h1111, 3, 1'b1, 42, "R8");
        check(dst_offset == last_acc_off, "R2", "offset after cfg change",
              64'(dst_offset), 64'(last_acc_off));

        // R5: broadcast on the new bus (0x1111 -> bus 0x044, phy 0x11)
        pkt_expect(16'h113F, 2, 1'b1, 43, "R5");

        // R7: full at the very first payload word loses the whole payload
        configure(16'hACD5);
        send_pkt(16'hACD5, 48'h0000_0000_0ACE, 3, 0, 44, 99, 16'h0);
        check(wr_cnt == 0, "R7", "full on first word writes", 64'(wr_cnt), 0);
        check(ovf_err == 1'b1, "R7", "full on first word ovf", 64'(ovf_err), 1);

        // R7: full during a missed packet raises no overflow
        send_pkt(16'hACD4, 48'h0, 3, 1, 45, 99, 16'h0);
        check(ovf_err == 1'b0, "R7", "full on missed packet", 64'(ovf_err), 0);
        check(hit == 1'b0, "R4", "missed after ovf", 64'(hit), 0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule